// File: doc/BRIEF.md
# Bus-attached static RAM

This block is a small static read/write memory that hangs off a shared data bus on which only one source may drive at a time. It holds two registers, an address register and a write-data register, and both take their value from the bus. The storage array is addressed by the address register. Two control inputs, a memory enable and a write enable, decide each cycle whether the array places a word on the bus, writes a word, or stays silent.

A typical sequence puts an address on the bus with the address-load strobe raised, then puts a data word on the bus with the data-load strobe raised. It then raises both enables for one cycle to store that word. To read, it loads the address and raises the memory enable alone; the addressed word appears on the bus output in that same cycle. The tri-state drivers are modelled as a data output plus a drive flag. The output carries zero whenever the flag is low.

Top module: `bus_sram`

## Requirements
- R1: A synchronous active-high reset clears the address register and the write-data register to zero, so after reset a read returns location 0 and a write stores the value zero.
- R2: Reset leaves the contents of the storage array untouched.
- R3: The address register takes the bus value at a rising edge when the address-load strobe was high before that edge, and otherwise holds its value.
- R4: The write-data register takes the bus value at a rising edge when the data-load strobe was high before that edge, and otherwise holds its value.
- R5: With the memory enable low, the drive flag is low and the data output is all zeros.
- R6: With the memory enable high and the write enable low, the drive flag is high and the data output carries the word at the location held in the address register, within the same cycle.
- R7: With both enables high, the drive flag is low and the data output is zero, and at the rising edge the write-data register's value is stored at the addressed location.
- R8: A write uses the address and data register values held before the edge, even when either register loads a new value at that same edge.
- R9: The write enable has no effect while the memory enable is low: nothing is stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| bus_in | input | DATA_W | Current value of the shared data bus |
| addr_ld | input | 1 | Load the address register from the bus at the next edge |
| data_ld | input | 1 | Load the write-data register from the bus at the next edge |
| mem_en | input | 1 | Memory enable |
| wr_en | input | 1 | Write enable, effective only with mem_en high |
| bus_out | output | DATA_W | Word offered to the bus; zero when not driving |
| bus_drive | output | 1 | High when the memory drives the bus |

## Verification
The assertions take for granted that the bus value and strobes are settled before each rising edge and that reset is held for at least one edge before any traffic. They also assume the array location being checked after a write was written at least once, because array words start unknown. The stimulus changes inputs shortly after each rising edge and samples outputs at the falling edge. It writes every location before reading any, so no read ever depends on an unwritten word.

// File: rtl/bus_sram_pkg.sv
package bus_sram_pkg;

    typedef enum logic [1:0] {
        MODE_OFF   = 2'd0,
        MODE_READ  = 2'd1,
        MODE_WRITE = 2'd2
    } mem_mode_e;

    typedef struct packed {
        logic enable;
        logic write;
    } mem_ctrl_t;

    function automatic mem_mode_e decode_mode(input mem_ctrl_t c);
        if (!c.enable)
            return MODE_OFF;
        else if (c.write)
            return MODE_WRITE;
        else
            return MODE_READ;
    endfunction

endpackage

// File: rtl/bus_sram_ldreg.sv
module bus_sram_ldreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (ld)
            q <= d;
    end

    // R3 / R4: load takes the bus value, no load holds
    a_r3_load_takes_bus: assert property (@(posedge clk) disable iff (rst)
        ld |=> q == $past(d));
    a_r4_hold_without_load: assert property (@(posedge clk) disable iff (rst)
        !ld |=> $stable(q));

endmodule

// File: rtl/bus_sram_ctrl.sv
module bus_sram_ctrl
    import bus_sram_pkg::*;
(
    input  mem_ctrl_t ctrl,
    output logic      drive,
    output logic      wr_stb
);

    mem_mode_e mode;

    always_comb begin
        mode   = decode_mode(ctrl);
        drive  = (mode == MODE_READ);
        wr_stb = (mode == MODE_WRITE);
    end

endmodule

// File: rtl/bus_sram_array.sv
module bus_sram_array #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[addr] <= wdata;
    end

    assign rdata = mem[addr];

endmodule

// File: rtl/bus_sram.sv
module bus_sram
    import bus_sram_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] bus_in,
    input  logic              addr_ld,
    input  logic              data_ld,
    input  logic              mem_en,
    input  logic              wr_en,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_drive
);

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic [DATA_W-1:0] rd_word;
    logic              wr_stb;
    mem_ctrl_t         ctrl;

    assign ctrl = '{enable: mem_en, write: wr_en};

    bus_sram_ldreg #(.W(ADDR_W)) u_addr_reg (
        .clk (clk),
        .rst (rst),
        .ld  (addr_ld),
        .d   (bus_in[ADDR_W-1:0]),
        .q   (addr_q)
    );

    bus_sram_ldreg #(.W(DATA_W)) u_data_reg (
        .clk (clk),
        .rst (rst),
        .ld  (data_ld),
        .d   (bus_in),
        .q   (data_q)
    );

    bus_sram_ctrl u_ctrl (
        .ctrl   (ctrl),
        .drive  (bus_drive),
        .wr_stb (wr_stb)
    );

    bus_sram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
        .clk   (clk),
        .we    (wr_stb),
        .addr  (addr_q),
        .wdata (data_q),
        .rdata (rd_word)
    );

    assign bus_out = bus_drive ? rd_word : '0;

    // R5: disabled memory stays off the bus
    a_r5_off_when_disabled: assert property (@(posedge clk) disable iff (rst)
        !mem_en |-> (!bus_drive && bus_out == '0));
    // R6: read mode drives the bus
    a_r6_drive_on_read: assert property (@(posedge clk) disable iff (rst)
        (mem_en && !wr_en) |-> bus_drive);
    // R7: write mode releases the bus
    a_r7_release_on_write: assert property (@(posedge clk) disable iff (rst)
        (mem_en && wr_en) |-> (!bus_drive && bus_out == '0));
    // R7 / R8: the pre-edge register values are stored
    a_r8_store_prior_regs: assert property (@(posedge clk) disable iff (rst)
        (mem_en && wr_en) |=> u_arr.mem[$past(addr_q)] == $past(data_q));
    // R9: no store while the memory is disabled
    a_r9_no_store_disabled: assert property (@(posedge clk) disable iff (rst)
        (!mem_en && !$isunknown(u_arr.mem[addr_q]))
            |=> u_arr.mem[$past(addr_q)] == $past(u_arr.mem[addr_q]));

endmodule

// File: tb/bus_sram_tb_top.sv
`timescale 1ns/1ps
module bus_sram_tb_top;

    localparam int AW    = 4;
    localparam int DW    = 8;
    localparam int DEPTH = 1 << AW;

    typedef struct {
        string          tag;
        logic           drv;
        logic [DW-1:0]  val;
    } exp_item_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [DW-1:0] bus_in = '0;
    logic          addr_ld = 1'b0;
    logic          data_ld = 1'b0;
    logic          mem_en = 1'b0;
    logic          wr_en = 1'b0;
    logic [DW-1:0] bus_out;
    logic          bus_drive;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    exp_item_t      exp_q[$];
    logic [DW-1:0]  ref_mem [DEPTH];
    logic [AW-1:0]  ref_addr;
    logic [DW-1:0]  ref_data;

    always #4 clk = ~clk;

    bus_sram #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .bus_in    (bus_in),
        .addr_ld   (addr_ld),
        .data_ld   (data_ld),
        .mem_en    (mem_en),
        .wr_en     (wr_en),
        .bus_out   (bus_out),
        .bus_drive (bus_drive)
    );

    // monitor: compare outputs against queued expectations at the falling edge
    always @(negedge clk) begin
        while (exp_q.size() > 0) begin
            exp_item_t it;
            it = exp_q.pop_front();
            checks++;
            if (bus_drive !== it.drv || bus_out !== it.val) begin
                fails++;
                $display("FAIL %s: drive=%0b out=%02h expected drive=%0b out=%02h",
                         it.tag, bus_drive, bus_out, it.drv, it.val);
            end
        end
    end

    function automatic logic [DW-1:0] pattern(input int k);
        return DW'((k * 37 + 11) ^ 8'h5A);
    endfunction

    task automatic push_exp(input string tag, input logic drv, input logic [DW-1:0] val);
        exp_item_t it;
        it.tag = tag;
        it.drv = drv;
        it.val = val;
        exp_q.push_back(it);
    endtask

    task automatic next_cycle();
        @(posedge clk);
        #1;
        addr_ld = 1'b0;
        data_ld = 1'b0;
        mem_en  = 1'b0;
        wr_en   = 1'b0;
    endtask

    task automatic load_addr(input logic [AW-1:0] a);
        bus_in  = DW'(a);
        addr_ld = 1'b1;
        next_cycle();
        ref_addr = a;
    endtask

    task automatic load_data(input logic [DW-1:0] d);
        bus_in  = d;
        data_ld = 1'b1;
        next_cycle();
        ref_data = d;
    endtask

    task automatic do_write(input string tag);
        mem_en = 1'b1;
        wr_en  = 1'b1;
        push_exp(tag, 1'b0, '0);
        next_cycle();
        ref_mem[ref_addr] = ref_data;
    endtask

    task automatic do_read(input string tag);
        mem_en = 1'b1;
        wr_en  = 1'b0;
        push_exp(tag, 1'b1, ref_mem[ref_addr]);
        next_cycle();
    endtask

    task automatic do_idle(input string tag, input logic we);
        mem_en = 1'b0;
        wr_en  = we;
        push_exp(tag, 1'b0, '0);
        next_cycle();
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: run hung, actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        ref_addr = '0;
        ref_data = '0;
        repeat (3) @(posedge clk);
        #1;
        // R5 while in reset with memory disabled
        push_exp("R5 reset idle", 1'b0, '0);
        @(posedge clk);
        #1;
        rst = 1'b0;

        // R3, R4, R7: fill every location
        for (int k = 0; k < DEPTH; k++) begin
            load_addr(AW'(k));
            load_data(pattern(k));
            do_write("R7 write releases bus");
        end
        // R6: read every location back
        for (int k = DEPTH - 1; k >= 0; k--) begin
            load_addr(AW'(k));
            do_read("R6 read addressed word");
        end

        // R9: write enable alone stores nothing
        load_addr(AW'(3));
        load_data(8'hEE);
        do_idle("R9 disabled with wr_en", 1'b1);
        do_idle("R5 disabled", 1'b0);
        do_read("R9 location unchanged");

        // R3: address held over idle cycles
        bus_in = 8'h0C;
        do_idle("R3 idle no load", 1'b0);
        do_idle("R3 idle no load", 1'b0);
        do_read("R3 address held");

        // R4: data register held, then write elsewhere
        load_addr(AW'(9));
        do_write("R4 held data written");
        do_read("R4 held data readback");

        // R8: loads at the same edge as the write
        load_addr(AW'(2));
        load_data(8'h77);
        bus_in  = 8'h0D;
        addr_ld = 1'b1;
        data_ld = 1'b1;
        mem_en  = 1'b1;
        wr_en   = 1'b1;
        push_exp("R8 write with loads", 1'b0, '0);
        next_cycle();
        ref_mem[2] = 8'h77;
        ref_addr   = AW'(13);
        ref_data   = 8'h0D;
        do_read("R8 new address not written");
        load_addr(AW'(2));
        do_read("R8 old address got old data");

        // R1, R2: reset clears registers, keeps array
        load_addr(AW'(0));
        load_data(8'hC3);
        do_write("R7 write location 0");
        load_addr(AW'(6));
        load_data(8'h99);
        rst = 1'b1;
        next_cycle();
        rst = 1'b0;
        ref_addr = '0;
        ref_data = '0;
        do_read("R1 R2 address cleared, array kept");
        load_addr(AW'(6));
        do_read("R2 location 6 kept");
        load_addr(AW'(0));
        do_write("R1 cleared data register stored");
        do_read("R1 zero written");

        repeat (2) next_cycle();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule